// File: doc/BRIEF.md
# Idle Mode Clock-Enable Controller

This block takes a processor core in and out of a low-power idle state by means of synchronous clock enables. Software writes an idle request bit. At the next instruction boundary the controller drops the core's clock enable. The peripheral clock enables stay high, so that timers and serial units can keep working and raise an interrupt. The watchdog's clock enable during idle follows its own idle-enable input. The brown-out detector enable is passed through unchanged in every state.

Idle ends when any interrupt request that is also enabled is present, or when reset is asserted. When an interrupt ends idle, the core clock enable returns and the request bit clears itself. A one-cycle wake pulse also goes out, so the core services the interrupt first and then resumes after the instruction that entered idle. A reset also ends idle, but it gives no wake pulse.

Top module: `idle_clkgate_ctl`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), `cpu_clk_en_o` is 1, `idle_bit_o` is 0, `wake_o` is 0 and `wdt_clk_en_o` is 1.
- R2: A cycle with `idle_set_i` high while the core runs sets `idle_bit_o` after that clock edge. The core clock enable stays 1 until an instruction boundary arrives.
- R3: A cycle with `insn_boundary_i` high while `idle_bit_o` is 1 drops `cpu_clk_en_o` to 0 after that edge. A boundary strobe while `idle_bit_o` is 0 has no effect.
- R4: With the default keep mask (all ones), every bit of `periph_clk_en_o` is 1 in both run and idle. A peripheral whose mask bit is 0 is enabled only while the core runs.
- R5: While the core runs, `wdt_clk_en_o` is 1. During idle it equals `wdt_idle_en_i`.
- R6: `bod_en_o` equals `bod_en_i` in run and in idle.
- R7: During idle, a cycle in which `irq_req_i & irq_en_i` is nonzero causes the following after that edge: `cpu_clk_en_o` returns to 1, `idle_bit_o` clears, and `wake_o` is 1 for exactly one cycle. This holds with the default of zero wake synchronizer stages.
- R8: During idle, requests whose enable bit is 0, and enables with no request, leave `cpu_clk_en_o` at 0.
- R9: Asserting reset during idle returns the block to the run state with `wake_o` at 0.
- R10: If an enabled request is already pending when idle is entered, idle lasts exactly one cycle. The block then wakes with the R7 behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_set_i | input | 1 | Write strobe setting the idle request bit |
| insn_boundary_i | input | 1 | Strobe marking an instruction boundary |
| irq_req_i | input | N_IRQ | Interrupt request lines |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| wdt_idle_en_i | input | 1 | Keep watchdog clocked during idle |
| bod_en_i | input | 1 | Brown-out detector enabled by configuration |
| cpu_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | N_PERIPH | Peripheral clock enables |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| bod_en_o | output | 1 | Brown-out detector enable |
| wake_o | output | 1 | One-cycle pulse on interrupt wake-up |
| idle_bit_o | output | 1 | Current state of the idle request bit |

## Verification
Every registered result (the idle bit, the core clock enable after a boundary, and the wake pulse with its clearing) is due one clock edge after the stimulus cycle. The watchdog, peripheral and brown-out enables are combinational from the state and follow within that same settled cycle. The driver applies inputs on the falling edge and queues the values expected after the next rising edge. The monitor pops each item one time unit after that rising edge, so each comparison falls exactly one edge after its stimulus. The asynchronous reset is checked directly, a short delay after reset is asserted.

// File: rtl/idle_clkgate_pkg.sv
package idle_clkgate_pkg;
   typedef enum logic {
      PWR_RUN  = 1'b0,
      PWR_IDLE = 1'b1
   } pwr_state_e;
endpackage

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
   parameter int N_IRQ        = 8,
   parameter int SYNC_STAGES  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_req_i,
   input  logic [N_IRQ-1:0] irq_en_i,
   output logic             wake_req_o
);
   logic [N_IRQ-1:0] req_seen;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign req_seen = irq_req_i;
      end else begin : g_sync
         logic [N_IRQ-1:0] sync_q [SYNC_STAGES];
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  sync_q[s] <= '0;
               end else if (s == 0) begin
                  sync_q[s] <= irq_req_i;
               end else begin
                  sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign req_seen = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign wake_req_o = |(req_seen & irq_en_i);
endmodule

// File: rtl/idle_ctl_fsm.sv
module idle_ctl_fsm
   import idle_clkgate_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idle_set_i,
   input  logic       insn_boundary_i,
   input  logic       wake_req_i,
   output pwr_state_e state_o,
   output logic       idle_bit_o,
   output logic       wake_o
);
   pwr_state_e state_q;
   logic       idle_bit_q;
   logic       wake_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PWR_RUN;
         idle_bit_q <= 1'b0;
         wake_q     <= 1'b0;
      end else begin
         wake_q <= 1'b0;
         unique case (state_q)
            PWR_RUN: begin
               if (idle_set_i) begin
                  idle_bit_q <= 1'b1;
               end
               if (idle_bit_q && insn_boundary_i) begin
                  state_q <= PWR_IDLE;
               end
            end
            PWR_IDLE: begin
               if (wake_req_i) begin
                  state_q    <= PWR_RUN;
                  idle_bit_q <= 1'b0;
                  wake_q     <= 1'b1;
               end
            end
            default: state_q <= PWR_RUN;
         endcase
      end
   end

   assign state_o    = state_q;
   assign idle_bit_o = idle_bit_q;
   assign wake_o     = wake_q;
endmodule

// File: rtl/idle_clk_en_gen.sv
module idle_clk_en_gen
   import idle_clkgate_pkg::*;
#(
   parameter int                N_PERIPH        = 4,
   parameter logic [N_PERIPH-1:0] PERIPH_KEEP_MASK = '1
) (
   input  pwr_state_e          state_i,
   input  logic                wdt_idle_en_i,
   input  logic                bod_en_i,
   output logic                cpu_clk_en_o,
   output logic [N_PERIPH-1:0] periph_clk_en_o,
   output logic                wdt_clk_en_o,
   output logic                bod_en_o
);
   logic core_run;

   assign core_run     = (state_i == PWR_RUN);
   assign cpu_clk_en_o = core_run;
   assign wdt_clk_en_o = core_run | wdt_idle_en_i;
   assign bod_en_o     = bod_en_i;

   generate
      for (genvar p = 0; p < N_PERIPH; p++) begin : g_periph
         if (PERIPH_KEEP_MASK[p]) begin : g_keep
            assign periph_clk_en_o[p] = 1'b1;
         end else begin : g_gated
            assign periph_clk_en_o[p] = core_run;
         end
      end
   endgenerate
endmodule

// File: rtl/idle_clkgate_ctl.sv
module idle_clkgate_ctl
   import idle_clkgate_pkg::*;
#(
   parameter int                  N_IRQ            = 8,
   parameter int                  N_PERIPH         = 4,
   parameter logic [N_PERIPH-1:0] PERIPH_KEEP_MASK = '1,
   parameter int                  WAKE_SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                idle_set_i,
   input  logic                insn_boundary_i,
   input  logic [N_IRQ-1:0]    irq_req_i,
   input  logic [N_IRQ-1:0]    irq_en_i,
   input  logic                wdt_idle_en_i,
   input  logic                bod_en_i,
   output logic                cpu_clk_en_o,
   output logic [N_PERIPH-1:0] periph_clk_en_o,
   output logic                wdt_clk_en_o,
   output logic                bod_en_o,
   output logic                wake_o,
   output logic                idle_bit_o
);
   generate
      if (N_IRQ < 1) begin : g_bad_irq
         $error("idle_clkgate_ctl: N_IRQ must be at least 1");
      end
      if (N_PERIPH < 1) begin : g_bad_periph
         $error("idle_clkgate_ctl: N_PERIPH must be at least 1");
      end
      if (WAKE_SYNC_STAGES < 0 || WAKE_SYNC_STAGES > 3) begin : g_bad_sync
         $error("idle_clkgate_ctl: WAKE_SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic       wake_req;
   pwr_state_e pwr_state;

   idle_wake_detect #(
      .N_IRQ       (N_IRQ),
      .SYNC_STAGES (WAKE_SYNC_STAGES)
   ) u_wake (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_req_i  (irq_req_i),
      .irq_en_i   (irq_en_i),
      .wake_req_o (wake_req)
   );

   idle_ctl_fsm u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .idle_set_i      (idle_set_i),
      .insn_boundary_i (insn_boundary_i),
      .wake_req_i      (wake_req),
      .state_o         (pwr_state),
      .idle_bit_o      (idle_bit_o),
      .wake_o          (wake_o)
   );

   idle_clk_en_gen #(
      .N_PERIPH         (N_PERIPH),
      .PERIPH_KEEP_MASK (PERIPH_KEEP_MASK)
   ) u_en (
      .state_i         (pwr_state),
      .wdt_idle_en_i   (wdt_idle_en_i),
      .bod_en_i        (bod_en_i),
      .cpu_clk_en_o    (cpu_clk_en_o),
      .periph_clk_en_o (periph_clk_en_o),
      .wdt_clk_en_o    (wdt_clk_en_o),
      .bod_en_o        (bod_en_o)
   );
endmodule

// File: rtl/idle_clkgate_ctl_chk.sv
module idle_clkgate_ctl_chk #(
   parameter int                  N_IRQ            = 8,
   parameter int                  N_PERIPH         = 4,
   parameter logic [N_PERIPH-1:0] PERIPH_KEEP_MASK = '1,
   parameter int                  WAKE_SYNC_STAGES = 0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                insn_boundary_i,
   input logic [N_IRQ-1:0]    irq_req_i,
   input logic [N_IRQ-1:0]    irq_en_i,
   input logic                wdt_idle_en_i,
   input logic                cpu_clk_en_o,
   input logic [N_PERIPH-1:0] periph_clk_en_o,
   input logic                wdt_clk_en_o,
   input logic                wake_o,
   input logic                idle_bit_o
);
   AST_BOUNDARY_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en_o && idle_bit_o && insn_boundary_i) |=> !cpu_clk_en_o); // R3

   AST_RUN_KEEPS_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en_o |-> (&periph_clk_en_o)); // R4

   AST_WDT_RUN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en_o |-> wdt_clk_en_o); // R5

   AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o); // R7

   AST_WAKE_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_en_o) |-> (!idle_bit_o && wake_o)); // R7

   generate
      if (WAKE_SYNC_STAGES == 0) begin : g_direct_chk
         AST_ENABLED_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (!cpu_clk_en_o && |(irq_req_i & irq_en_i)) |=> (cpu_clk_en_o && wake_o)); // R7

         AST_MASKED_IRQ_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (!cpu_clk_en_o && !(|(irq_req_i & irq_en_i))) |=> !cpu_clk_en_o); // R8
      end
   endgenerate
endmodule

bind idle_clkgate_ctl idle_clkgate_ctl_chk #(
   .N_IRQ            (N_IRQ),
   .N_PERIPH         (N_PERIPH),
   .PERIPH_KEEP_MASK (PERIPH_KEEP_MASK),
   .WAKE_SYNC_STAGES (WAKE_SYNC_STAGES)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .insn_boundary_i (insn_boundary_i),
   .irq_req_i       (irq_req_i),
   .irq_en_i        (irq_en_i),
   .wdt_idle_en_i   (wdt_idle_en_i),
   .cpu_clk_en_o    (cpu_clk_en_o),
   .periph_clk_en_o (periph_clk_en_o),
   .wdt_clk_en_o    (wdt_clk_en_o),
   .wake_o          (wake_o),
   .idle_bit_o      (idle_bit_o)
);

// File: tb/idle_clkgate_ctl_tb_top.sv
module idle_clkgate_ctl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NI = 8;
   localparam int NP = 4;
   localparam int WDOG_CYCLES = 5000;

   typedef struct {
      logic  cpu;
      logic  idle;
      logic  wake;
      logic  wdt;
      logic  bod;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          idle_set = 1'b0;
   logic          boundary = 1'b0;
   logic [NI-1:0] irq_req = '0;
   logic [NI-1:0] irq_en = '0;
   logic          wdt_idle_en = 1'b0;
   logic          bod_en = 1'b1;

   logic          cpu_clk_en;
   logic [NP-1:0] periph_clk_en;
   logic          wdt_clk_en;
   logic          bod_en_out;
   logic          wake;
   logic          idle_bit;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   finished = 1'b0;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   idle_clkgate_ctl #(.N_IRQ(NI), .N_PERIPH(NP)) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .idle_set_i      (idle_set),
      .insn_boundary_i (boundary),
      .irq_req_i       (irq_req),
      .irq_en_i        (irq_en),
      .wdt_idle_en_i   (wdt_idle_en),
      .bod_en_i        (bod_en),
      .cpu_clk_en_o    (cpu_clk_en),
      .periph_clk_en_o (periph_clk_en),
      .wdt_clk_en_o    (wdt_clk_en),
      .bod_en_o        (bod_en_out),
      .wake_o          (wake),
      .idle_bit_o      (idle_bit)
   );

   task automatic check1(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: apply inputs on the falling edge, queue what must hold after the next rising edge
   task automatic step(input logic s, input logic b, input logic [NI-1:0] rq,
                       input logic [NI-1:0] en, input logic wdi, input logic bod,
                       input logic e_cpu, input logic e_idle, input logic e_wake,
                       input logic e_wdt, input string tag);
      exp_t e;
      @(negedge clk);
      idle_set    = s;
      boundary    = b;
      irq_req     = rq;
      irq_en      = en;
      wdt_idle_en = wdi;
      bod_en      = bod;
      e.cpu  = e_cpu;
      e.idle = e_idle;
      e.wake = e_wake;
      e.wdt  = e_wdt;
      e.bod  = bod;
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // monitor: one time unit after each rising edge, compare against the oldest queued item
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check1({e.tag, " cpu_clk_en"}, {7'd0, cpu_clk_en}, {7'd0, e.cpu});
         check1({e.tag, " idle_bit"},   {7'd0, idle_bit},   {7'd0, e.idle});
         check1({e.tag, " wake"},       {7'd0, wake},       {7'd0, e.wake});
         check1({e.tag, " R5 wdt_clk_en"}, {7'd0, wdt_clk_en}, {7'd0, e.wdt});
         check1({e.tag, " R6 bod_en"},  {7'd0, bod_en_out}, {7'd0, e.bod});
         check1({e.tag, " R4 periph"},  {4'd0, periph_clk_en}, 8'h0F);
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (WDOG_CYCLES) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      #(CLK_PERIOD*2 + 2);
      check1("R1 cpu_clk_en", {7'd0, cpu_clk_en}, 8'd1);
      check1("R1 idle_bit",   {7'd0, idle_bit},   8'd0);
      check1("R1 wake",       {7'd0, wake},       8'd0);
      check1("R1 wdt_clk_en", {7'd0, wdt_clk_en}, 8'd1);
      @(negedge clk);
      rst_n = 1'b1;

      //    s  b  req    en     wdi bod  cpu idl wak wdt
      step(0, 0, 8'h00, 8'h00, 0,  1,   1,  0,  0,  1, "R1 run after reset");
      step(1, 0, 8'h00, 8'h00, 0,  1,   1,  1,  0,  1, "R2 set idle bit");
      step(0, 0, 8'h00, 8'h00, 0,  1,   1,  1,  0,  1, "R2 wait boundary");
      step(0, 1, 8'h00, 8'h00, 0,  1,   0,  1,  0,  0, "R3 enter idle");
      step(0, 0, 8'h01, 8'h02, 0,  1,   0,  1,  0,  0, "R8 masked request");
      step(0, 0, 8'h00, 8'hFF, 0,  0,   0,  1,  0,  0, "R8 enable without request");
      step(0, 0, 8'h00, 8'hFF, 1,  0,   0,  1,  0,  1, "R5 wdt kept in idle");
      step(0, 0, 8'h80, 8'h80, 1,  1,   1,  0,  1,  1, "R7 wake on enabled irq");
      step(0, 0, 8'h00, 8'h80, 0,  1,   1,  0,  0,  1, "R7 wake pulse ends");
      step(0, 1, 8'h00, 8'h00, 0,  1,   1,  0,  0,  1, "R3 boundary with bit clear");
      step(1, 0, 8'h00, 8'h00, 0,  1,   1,  1,  0,  1, "R10 set idle bit");
      step(0, 1, 8'h04, 8'h04, 0,  1,   0,  1,  0,  0, "R10 enter with pending irq");
      step(0, 0, 8'h04, 8'h04, 0,  1,   1,  0,  1,  1, "R10 immediate wake");
      step(0, 0, 8'h00, 8'h00, 0,  1,   1,  0,  0,  1, "R10 back to run");
      step(1, 0, 8'h00, 8'h00, 0,  1,   1,  1,  0,  1, "R9 set idle bit");
      step(0, 1, 8'h00, 8'h00, 0,  1,   0,  1,  0,  0, "R9 enter idle");
      step(0, 0, 8'h00, 8'h00, 0,  1,   0,  1,  0,  0, "R9 idle holds");

      @(negedge clk);
      boundary = 1'b0;
      rst_n = 1'b0;
      #2;
      check1("R9 reset cpu_clk_en", {7'd0, cpu_clk_en}, 8'd1);
      check1("R9 reset idle_bit",   {7'd0, idle_bit},   8'd0);
      check1("R9 reset wake",       {7'd0, wake},       8'd0);
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 8'h00, 8'h00, 0,  1,   1,  0,  0,  1, "R9 run after reset");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule